// File: doc/BRIEF.md
# Radar Command Packet Dispatcher

This block sits behind the command link of a multi-channel radar receiver. Command packets arrive one byte per cycle on a valid/ready stream that marks the first and the last byte. The block reads a four-byte header, discards packets that are not addressed to it, decodes the command, and raises a one-cycle start strobe toward the selected mode engine. It then forwards the payload as 16-bit words and reports, at the end of the packet, whether the trailing checksum matched.

A configuration command assigns the unit its own identifier. That identifier is used for address filtering on every later packet. It also decides whether this unit acts as the designated calibration receiver while a transmit or receive calibration command is in progress. The mode engines share one busy line. While it is high, the input stream is stalled.

Top module: `radar_cmd_dispatch`

## Requirements
- R1: After reset the unit identifier is 0xFF, and cmd_start, pay_valid, done, csum_ok and is_cal_unit are all low.
- R2: The first byte of a packet is its destination. A packet is kept only when the destination equals the stored identifier or the broadcast value 0xFF. A packet that is not kept produces no strobe, no payload words and no done pulse.
- R3: The second byte is the command code: 0 self-test, 1 configuration, 2 dwell, 3 transmit calibration, 4 receive calibration, 5 calibration upload, 6 status, 7 debug. A code above 7 drops the packet. One cycle after the fourth header byte is accepted, a kept packet pulses bit <code> of cmd_start for one cycle. In that same cycle cmd_code carries the code and pay_len carries the length.
- R4: Bytes three and four hold the payload length in 16-bit words, high byte first. Each payload word is sent high byte first. One cycle after its second byte is accepted, it appears on pay_word with a one-cycle pay_valid.
- R5: The payload words are followed by a 16-bit checksum, high byte first. It is the modulo-65536 sum of the payload words. The byte carrying the end marker of a kept packet with a complete header causes a done pulse one cycle later. csum_ok is high with done only when that byte is the second checksum byte and the sum matches.
- R6: A configuration packet that ends with csum_ok and carries at least one word loads the low byte of its first word as the new identifier. The new identifier is visible in the cycle of done. No other packet changes the identifier.
- R7: is_cal_unit is high from the cycle of a calibration command's strobe until its done pulse, but only when the identifier equals the calibration identifier parameter (default 0x12).
- R8: in_ready is the inverse of eng_busy. A byte offered while in_ready is low is not consumed.
- R9: A byte marked as first always restarts header parsing. A byte without the first-byte marker that arrives outside a packet is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| in_ready | output | 1 | Input stream may advance |
| eng_busy | input | 1 | A mode engine is working |
| cmd_start | output | 8 | One-hot start strobe per command code |
| cmd_code | output | 3 | Code of the started command |
| pay_len | output | 16 | Payload length in words, valid with the strobe |
| pay_valid | output | 1 | Payload word strobe |
| pay_word | output | 16 | Payload word |
| done | output | 1 | End-of-packet pulse |
| csum_ok | output | 1 | Checksum and length matched, valid with done |
| unit_id | output | 8 | Stored unit identifier |
| is_cal_unit | output | 1 | This unit is the calibration receiver for the current command |

## Verification
Every registered result is due exactly one clock after the accepted byte that causes it. The strobe and length follow the fourth header byte. A payload word follows its low byte. Done, csum_ok and a new identifier follow the end-marked byte. The bench model takes the same input bytes at the rising edge and advances its expected outputs by one cycle. Both are compared at the falling edge, so each comparison lands on the cycle the result is due. Readiness is combinational, so it is compared at the rising edge, where the busy input is stable.

// File: rtl/radar_cmd_dispatch.sv
module radar_cmd_dispatch #(
  parameter logic [7:0] BCAST_ADDR = 8'hFF,
  parameter logic [7:0] CAL_UNIT   = 8'h12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        in_ready,
  input  logic        eng_busy,
  output logic [7:0]  cmd_start,
  output logic [2:0]  cmd_code,
  output logic [15:0] pay_len,
  output logic        pay_valid,
  output logic [15:0] pay_word,
  output logic        done,
  output logic        csum_ok,
  output logic [7:0]  unit_id,
  output logic        is_cal_unit
);
  localparam int LEN_W = 16;
  localparam int CNT_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] C_CFG = 3'd1, C_TXC = 3'd3, C_RXC = 3'd4;

  logic [CNT_W-1:0] bcnt, pos, pay_end;
  logic             in_pkt, keep_q, keep_now, in_cal;
  logic [2:0]       code_q;
  logic [LEN_W-1:0] len_q, len_now;
  logic [7:0]       hi_q, pend_q;
  logic [15:0]      sum_q, word_now;
  logic             fire, take, is_word, fin, ok_now;

  assign in_ready = ~eng_busy;
  assign fire     = in_valid & in_ready;
  assign take     = fire & (in_sop | in_pkt);
  assign pos      = in_sop ? '0 : bcnt;
  assign len_now  = (pos == CNT_W'(3)) ? {len_q[15:8], in_data} : len_q;
  assign pay_end  = {1'b0, len_now, 1'b0} + CNT_W'(4);
  assign word_now = {hi_q, in_data};
  assign is_word  = (pos >= CNT_W'(4)) && (pos < pay_end) && pos[0];
  assign ok_now   = (pos == pay_end + CNT_W'(1)) && (sum_q == word_now);
  assign fin      = take & in_eop & keep_now & (pos >= CNT_W'(3));

  always_comb begin
    if (pos == '0)               keep_now = (in_data == unit_id) || (in_data == BCAST_ADDR);
    else if (pos == CNT_W'(1))   keep_now = keep_q && (in_data < 8'd8);
    else                         keep_now = keep_q;
  end

  assign cmd_code    = code_q;
  assign pay_len     = len_q;
  assign is_cal_unit = in_cal && (unit_id == CAL_UNIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      in_pkt    <= 1'b0;
      keep_q    <= 1'b0;
      in_cal    <= 1'b0;
      code_q    <= '0;
      len_q     <= '0;
      hi_q      <= '0;
      pend_q    <= '0;
      sum_q     <= '0;
      unit_id   <= 8'hFF;
      cmd_start <= '0;
      pay_valid <= 1'b0;
      pay_word  <= '0;
      done      <= 1'b0;
      csum_ok   <= 1'b0;
    end else begin
      cmd_start <= '0;
      pay_valid <= 1'b0;
      done      <= 1'b0;
      csum_ok   <= 1'b0;
      if (take) begin
        hi_q   <= in_data;
        bcnt   <= (pos == CNT_MAX) ? pos : pos + CNT_W'(1);
        in_pkt <= ~in_eop;
        keep_q <= keep_now;
        if (pos == '0) begin
          in_cal <= 1'b0;
          sum_q  <= '0;
        end
        if (pos == CNT_W'(1)) code_q <= in_data[2:0];
        if (pos == CNT_W'(2)) len_q[15:8] <= in_data;
        if (pos == CNT_W'(3)) begin
          len_q[7:0] <= in_data;
          if (keep_now) begin
            cmd_start <= 8'd1 << code_q;
            in_cal    <= (code_q == C_TXC) || (code_q == C_RXC);
          end
        end
        if (keep_now && is_word) begin
          pay_valid <= 1'b1;
          pay_word  <= word_now;
          sum_q     <= sum_q + word_now;
          if (pos == CNT_W'(5)) pend_q <= in_data;
        end
        if (fin) begin
          done    <= 1'b1;
          csum_ok <= ok_now;
          in_cal  <= 1'b0;
          if (ok_now && code_q == C_CFG && len_now != '0) unit_id <= pend_q;
        end
      end
    end
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_start)) else $error("start strobe not one-hot"); // R3
  AST_START_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_start) |-> $past(in_valid && in_ready)) else $error("strobe without byte"); // R3
  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready && in_eop)) else $error("done without end byte"); // R5
  AST_OK_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    csum_ok |-> done) else $error("csum_ok outside done"); // R5
  AST_ID_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_id) |-> (done && csum_ok)) else $error("identifier changed"); // R6
  AST_CAL_ID: assert property (@(posedge clk) disable iff (!rst_n)
    is_cal_unit |-> (unit_id == CAL_UNIT)) else $error("cal flag on wrong unit"); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !in_ready) else $error("ready while busy"); // R8
endmodule

// File: tb/radar_cmd_dispatch_tb.sv
module radar_cmd_dispatch_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, eng_busy = 0;
  logic [7:0] in_data = 0;
  logic in_ready, pay_valid, done, csum_ok, is_cal_unit;
  logic [7:0] cmd_start, unit_id;
  logic [2:0] cmd_code;
  logic [15:0] pay_len, pay_word;

  radar_cmd_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready), .eng_busy(eng_busy),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .pay_len(pay_len),
    .pay_valid(pay_valid), .pay_word(pay_word), .done(done), .csum_ok(csum_ok),
    .unit_id(unit_id), .is_cal_unit(is_cal_unit));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit started = 0;

  int m_in = 0, m_pos = 0, m_keep = 0, m_code = 0, m_len = 0, m_hi = 0;
  int m_sum = 0, m_id = 255, m_pend = 0, m_cal = 0;
  int e_start = 0, e_code = 0, e_len = 0, e_pv = 0, e_word = 0, e_done = 0, e_ok = 0;

  always @(posedge clk) begin
    if (started) begin
      vectors++;
      if (in_ready !== !eng_busy) begin
        errors++;
        $display("FAIL R8 in_ready=%0b expected %0b", in_ready, !eng_busy);
      end
    end
    e_start = 0; e_pv = 0; e_done = 0; e_ok = 0;
    if (!rst_n) begin
      m_in = 0; m_pos = 0; m_keep = 0; m_id = 255; m_cal = 0; e_word = 0;
    end else if (in_valid && !eng_busy && (in_sop || m_in != 0)) begin
      int pos, d;
      d = in_data;
      pos = in_sop ? 0 : m_pos;
      if (pos == 0) begin
        m_keep = (d == m_id || d == 255); m_cal = 0;
      end
      if (pos == 1) begin
        if (d > 7) m_keep = 0;
        m_code = d % 8;
      end
      if (pos == 2) m_len = d * 256;
      if (pos == 3) begin
        m_len = m_len + d;
        if (m_keep != 0) begin
          e_start = 1 << m_code; e_code = m_code; e_len = m_len; m_sum = 0;
          m_cal = (m_code == 3 || m_code == 4);
        end
      end
      if (pos >= 4 && pos < 2 * m_len + 4 && (pos % 2) == 1 && m_keep != 0) begin
        e_pv = 1; e_word = m_hi * 256 + d;
        m_sum = (m_sum + e_word) % 65536;
        if (pos == 5) m_pend = d;
      end
      if (in_eop && m_keep != 0 && pos >= 3) begin
        e_done = 1;
        e_ok = (pos == 2 * m_len + 5) && (m_sum == m_hi * 256 + d);
        if (e_ok != 0 && m_code == 1 && m_len >= 1) m_id = m_pend;
        m_cal = 0;
      end
      m_hi = d;
      m_pos = pos + 1;
      m_in = !in_eop;
    end
  end

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (started) begin
      string rr;
      int e_cal;
      vectors++;
      rr = rst_n ? "R3" : "R1";
      e_cal = (m_cal != 0 && m_id == 8'h12);
      if (cmd_start !== 8'(e_start)) fail(rr, "cmd_start", cmd_start, e_start);
      if (e_start != 0 && cmd_code !== 3'(e_code)) fail("R3", "cmd_code", cmd_code, e_code);
      if (e_start != 0 && pay_len !== 16'(e_len)) fail("R4", "pay_len", pay_len, e_len);
      if (pay_valid !== (e_pv != 0)) fail(rst_n ? "R4" : "R1", "pay_valid", pay_valid, e_pv);
      if (e_pv != 0 && pay_word !== 16'(e_word)) fail("R4", "pay_word", pay_word, e_word);
      if (done !== (e_done != 0)) fail(rst_n ? "R5" : "R1", "done", done, e_done);
      if (csum_ok !== (e_ok != 0)) fail(rst_n ? "R5" : "R1", "csum_ok", csum_ok, e_ok);
      if (unit_id !== 8'(m_id)) fail(rst_n ? "R6" : "R1", "unit_id", unit_id, m_id);
      if (is_cal_unit !== (e_cal != 0)) fail(rst_n ? "R7" : "R1", "is_cal_unit", is_cal_unit, e_cal);
    end
  end

  logic [7:0] pkt[$];
  int wq[$];

  task automatic mk(int dest, int code, bit bad);
    int s = 0;
    pkt.delete();
    pkt.push_back(8'(dest)); pkt.push_back(8'(code));
    pkt.push_back(8'(wq.size() >> 8)); pkt.push_back(8'(wq.size()));
    foreach (wq[i]) begin
      pkt.push_back(8'(wq[i] >> 8)); pkt.push_back(8'(wq[i]));
      s = (s + wq[i]) % 65536;
    end
    if (bad) s = (s + 1) % 65536;
    pkt.push_back(8'(s >> 8)); pkt.push_back(8'(s));
  endtask

  task automatic send(int gap, int busy_pre, bit sop_first, int sop2);
    for (int i = 0; i < pkt.size(); i++) begin
      for (int k = 0; k <= (i == 0 ? busy_pre : 0); k++) begin
        @(negedge clk);
        in_valid = 1; in_data = pkt[i];
        in_sop = (i == 0 && sop_first) || (i == sop2);
        in_eop = (i == pkt.size() - 1);
        eng_busy = (i == 0 && k < busy_pre);
        @(posedge clk);
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 0; eng_busy = 0;
        @(posedge clk);
      end
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; eng_busy = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    started = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);
    wq = '{16'h0012};                  mk(8'hFF, 1, 0); send(0, 0, 1, -1); // R6 config
    wq = '{16'h1111, 16'h2222};        mk(8'h34, 2, 0); send(0, 0, 1, -1); // R2 dropped
    wq = '{16'hABCD, 16'hFFFF, 16'h0102}; mk(8'h12, 2, 0); send(1, 0, 1, -1); // R4 R5
    wq = '{16'h5555};                  mk(8'h12, 6, 1); send(0, 0, 1, -1); // R5 bad sum
    wq = '{16'h0001};                  mk(8'h12, 9, 0); send(0, 0, 1, -1); // R3 bad code
    wq = {};                           mk(8'hFF, 0, 0); send(0, 0, 1, -1); // R5 empty
    wq = '{16'h0A0B, 16'h0C0D};        mk(8'h12, 3, 0); send(0, 3, 1, -1); // R7 R8
    wq = '{16'h0020};                  mk(8'h12, 1, 1); send(0, 0, 1, -1); // R6 bad sum
    wq = '{16'h0020, 16'h7777};        mk(8'h12, 1, 0); send(2, 0, 1, -1); // R6 good
    wq = '{16'h1234};                  mk(8'h12, 4, 0); send(0, 0, 1, -1); // R2 old id
    wq = '{16'h1234};                  mk(8'h20, 4, 0); send(0, 2, 1, -1); // R7 not cal
    wq = '{16'h0102, 16'h0304, 16'h0506}; mk(8'h20, 2, 0);
    repeat (3) void'(pkt.pop_back());  send(0, 0, 1, -1);                  // R5 early end
    wq = '{16'h9999};                  mk(8'h20, 7, 0); send(0, 0, 0, -1); // R9 stray
    wq = '{16'h4242};                  mk(8'h20, 5, 0);
    pkt.push_front(8'h03); pkt.push_front(8'h20);
    send(0, 0, 1, 2);                                                      // R9 restart
    wq = '{16'hFFFF, 16'hFFFF};        mk(8'hFF, 7, 0); send(0, 0, 1, -1); // R5 wrap
    repeat (5) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule